// File: doc/BRIEF.md
# Address-Space-Tagged Translation Lookaside Buffer

This block is a small, fully associative translation cache. A lookup presents a 32-bit virtual address and the current address-space identifier (ASID). The upper 20 bits of the address are the virtual page number and the lower 12 bits are the byte offset inside a 4 KB page. The block searches every slot in parallel. When a slot matches, it returns the physical address, the control bits stored with the entry, and the previous state of the entry's reference flag. Lookups use a valid/ready request channel and a valid/ready response channel. One response register sits between the two channels.

Software fills the table through a plain write port. The target slot comes from one of two dedicated registers. The first is an index register that software loads. The second is a free-running countdown register that gives a pseudo-random victim slot. Three other controls act on every slot in a single cycle: a flush command that invalidates all slots, a command that clears all reference flags, and a reset.

Back-pressure rules: a request transfers on a clock edge where `req_valid` and `req_ready` are both high. `req_ready` is high whenever the response register is empty or is being drained in the same cycle. A response that has not been taken keeps all of its fields unchanged until `resp_ready` is high.

Top module: `tlb_asid`

## Requirements
- R1: The virtual page number is `lk_va[31:12]` and the offset is `lk_va[11:0]`. On a hit, `resp_pa` equals `{ppn, lk_va[11:0]}` and `resp_ctrl` equals the stored control bits.
- R2: A slot hits only if it is valid, its stored page number equals the request's page number, and its stored ASID equals `lk_asid`. A mismatch in any one of these gives a miss.
- R3: On a miss, `resp_hit`, `resp_pa`, `resp_ctrl` and `resp_ref` are all zero.
- R4: When several slots hit, the lowest-numbered slot supplies the result.
- R5: With `wr_random` = 0, a write goes to the slot held in the index register. `idx_load` loads `idx_value` into that register only if `idx_value` is below ENTRIES. A larger value leaves the register unchanged.
- R6: The random register resets to ENTRIES-1 and decrements on every clock, wrapping from 0 to ENTRIES-1. Its value appears on `rnd_idx`. With `wr_random` = 1, a write goes to the slot that `rnd_idx` shows in the write cycle.
- R7: An accepted lookup that hits sets the reference flag of the slot that hit. `resp_ref` reports the value the flag had before that lookup. A write leaves the written slot valid with its flag cleared.
- R8: `ref_clear` clears the reference flags of all slots in one cycle. It takes priority over a hit that sets a flag in the same cycle.
- R9: `flush` invalidates all slots in one cycle. It takes priority over a write in the same cycle.
- R10: A response appears one clock after its request is accepted. `req_ready` = !resp_valid || resp_ready. While `resp_valid` is high and `resp_ready` is low, the response stays unchanged.
- R11: After reset, `resp_valid` is low, every slot is invalid, and the index register holds 0.
- R12: A lookup sees the table as it was before any write, flush or clear that happens in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Lookup request valid |
| req_ready | output | 1 | Lookup request can be accepted |
| lk_va | input | 32 | Virtual address to translate |
| lk_asid | input | 8 | Current address-space identifier |
| resp_valid | output | 1 | Response register full |
| resp_ready | input | 1 | Consumer takes the response |
| resp_hit | output | 1 | Translation found |
| resp_pa | output | 32 | Physical address (zero on miss) |
| resp_ctrl | output | 4 | Control bits of the hitting slot |
| resp_ref | output | 1 | Reference flag of the hitting slot before the access |
| wr_en | input | 1 | Install an entry |
| wr_random | input | 1 | 1: random register picks slot, 0: index register |
| wr_asid | input | 8 | ASID of new entry |
| wr_vpn | input | 20 | Virtual page number of new entry |
| wr_ppn | input | 20 | Physical page number of new entry |
| wr_ctrl | input | 4 | Control bits of new entry |
| idx_load | input | 1 | Load the index register |
| idx_value | input | 6 | Value for the index register |
| rnd_idx | output | 5 | Current random register value |
| flush | input | 1 | Invalidate all slots |
| ref_clear | input | 1 | Clear all reference flags |

## Verification
Some behaviours are checked by assertions on every cycle:
- the random register stays in range and steps down with wrap-around;
- an out-of-range index load is ignored;
- a flush empties the table and a clear drops every reference flag;
- a hit marks its slot;
- a miss drives zeros;
- a stalled response holds steady;
- the matcher never reports a slot that did not match, or one that has a lower-numbered matching neighbour.

Other behaviours only the scenarios can show, because they depend on values the bench chose:
- the correct translated address for particular entries;
- which slot a random or indexed write actually replaced;
- priority between duplicates;
- the ordering of same-cycle write, flush and clear;
- the previous-flag value reported in `resp_ref`.

// File: rtl/tlb_pkg.sv
package tlb_pkg;
  parameter int unsigned TLB_ASID_W = 8;
  parameter int unsigned TLB_VPN_W  = 20;
  parameter int unsigned TLB_OFF_W  = 12;
  parameter int unsigned TLB_PPN_W  = 20;
  parameter int unsigned TLB_CTRL_W = 4;

  typedef struct packed {
    logic                  valid;
    logic                  refd;
    logic [TLB_ASID_W-1:0] asid;
    logic [TLB_VPN_W-1:0]  vpn;
    logic [TLB_PPN_W-1:0]  ppn;
    logic [TLB_CTRL_W-1:0] ctrl;
  } tlb_entry_t;
endpackage

// File: rtl/tlb_victim_regs.sv
module tlb_victim_regs #(
  parameter int unsigned ENTRIES = 32,
  localparam int unsigned IDX_W = $clog2(ENTRIES)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             idx_load,
  input  logic [IDX_W:0]   idx_value,
  output logic [IDX_W-1:0] idx_q,
  output logic [IDX_W-1:0] rnd_q
);
  localparam logic [IDX_W-1:0] TOP = IDX_W'(ENTRIES - 1);
  localparam logic [IDX_W:0]   LIM = (IDX_W+1)'(ENTRIES);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      idx_q <= '0;
      rnd_q <= TOP;
    end else begin
      if (idx_load && (idx_value < LIM)) idx_q <= idx_value[IDX_W-1:0];
      rnd_q <= (rnd_q == '0) ? TOP : rnd_q - 1'b1;
    end
  end

  p_rnd_range_r6: assert property (@(posedge clk) disable iff (!rst_n)
    int'(rnd_q) < int'(ENTRIES));
  p_rnd_step_r6: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> rnd_q == (($past(rnd_q) == '0) ? TOP : $past(rnd_q) - 1'b1));
  p_idx_ignore_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (idx_load && idx_value >= LIM) |=> $stable(idx_q));
endmodule

// File: rtl/tlb_match.sv
module tlb_match
  import tlb_pkg::*;
#(
  parameter int unsigned ENTRIES = 32,
  localparam int unsigned IDX_W = $clog2(ENTRIES)
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  tlb_entry_t            tab [ENTRIES],
  input  logic [TLB_VPN_W-1:0]  look_vpn,
  input  logic [TLB_ASID_W-1:0] look_asid,
  output logic                  hit,
  output logic [IDX_W-1:0]      hit_idx
);
  logic [ENTRIES-1:0] match_vec;

  for (genvar g = 0; g < ENTRIES; g++) begin : g_cmp
    assign match_vec[g] = tab[g].valid && (tab[g].vpn == look_vpn)
                          && (tab[g].asid == look_asid);
  end

  always_comb begin
    hit     = 1'b0;
    hit_idx = '0;
    for (int i = ENTRIES - 1; i >= 0; i--) begin
      if (match_vec[i]) begin
        hit     = 1'b1;
        hit_idx = IDX_W'(i);
      end
    end
  end

  p_hit_real_r2: assert property (@(posedge clk) disable iff (!rst_n)
    hit |-> match_vec[hit_idx]);
  p_lowest_r4: assert property (@(posedge clk) disable iff (!rst_n)
    hit |-> ((match_vec << (ENTRIES - int'(hit_idx))) == '0));
  p_miss_none_r3: assert property (@(posedge clk) disable iff (!rst_n)
    !hit |-> (match_vec == '0));
endmodule

// File: rtl/tlb_asid.sv
module tlb_asid
  import tlb_pkg::*;
#(
  parameter int unsigned ENTRIES = 32,
  localparam int unsigned IDX_W = $clog2(ENTRIES),
  localparam int unsigned VA_W  = TLB_VPN_W + TLB_OFF_W,
  localparam int unsigned PA_W  = TLB_PPN_W + TLB_OFF_W
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  req_valid,
  output logic                  req_ready,
  input  logic [VA_W-1:0]       lk_va,
  input  logic [TLB_ASID_W-1:0] lk_asid,
  output logic                  resp_valid,
  input  logic                  resp_ready,
  output logic                  resp_hit,
  output logic [PA_W-1:0]       resp_pa,
  output logic [TLB_CTRL_W-1:0] resp_ctrl,
  output logic                  resp_ref,
  input  logic                  wr_en,
  input  logic                  wr_random,
  input  logic [TLB_ASID_W-1:0] wr_asid,
  input  logic [TLB_VPN_W-1:0]  wr_vpn,
  input  logic [TLB_PPN_W-1:0]  wr_ppn,
  input  logic [TLB_CTRL_W-1:0] wr_ctrl,
  input  logic                  idx_load,
  input  logic [IDX_W:0]        idx_value,
  output logic [IDX_W-1:0]      rnd_idx,
  input  logic                  flush,
  input  logic                  ref_clear
);
  tlb_entry_t         tab_q [ENTRIES];
  logic [IDX_W-1:0]   idx_q, rnd_q, wr_slot, hit_idx;
  logic               hit, accept;
  logic [ENTRIES-1:0] valid_vec, ref_vec;
  tlb_entry_t         hit_ent;

  tlb_victim_regs #(.ENTRIES(ENTRIES)) u_victim (
    .clk(clk), .rst_n(rst_n), .idx_load(idx_load), .idx_value(idx_value),
    .idx_q(idx_q), .rnd_q(rnd_q)
  );

  tlb_match #(.ENTRIES(ENTRIES)) u_match (
    .clk(clk), .rst_n(rst_n), .tab(tab_q),
    .look_vpn(lk_va[VA_W-1:TLB_OFF_W]), .look_asid(lk_asid),
    .hit(hit), .hit_idx(hit_idx)
  );

  assign rnd_idx   = rnd_q;
  assign wr_slot   = wr_random ? rnd_q : idx_q;
  assign req_ready = !resp_valid || resp_ready;
  assign accept    = req_valid && req_ready;
  assign hit_ent   = tab_q[hit_idx];

  for (genvar g = 0; g < ENTRIES; g++) begin : g_flags
    assign valid_vec[g] = tab_q[g].valid;
    assign ref_vec[g]   = tab_q[g].refd;
  end

  // Table storage: flush beats write, write and clear beat a hit mark.
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i < ENTRIES; i++) tab_q[i] <= '0;
    end else begin
      for (int i = 0; i < ENTRIES; i++) begin
        if (wr_en && wr_slot == IDX_W'(i)) begin
          tab_q[i].valid <= !flush;
          tab_q[i].refd  <= 1'b0;
          tab_q[i].asid  <= wr_asid;
          tab_q[i].vpn   <= wr_vpn;
          tab_q[i].ppn   <= wr_ppn;
          tab_q[i].ctrl  <= wr_ctrl;
        end else begin
          if (flush) tab_q[i].valid <= 1'b0;
          if (ref_clear) tab_q[i].refd <= 1'b0;
          else if (accept && hit && hit_idx == IDX_W'(i)) tab_q[i].refd <= 1'b1;
        end
      end
    end
  end

  // Response register
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      resp_valid <= 1'b0;
      resp_hit   <= 1'b0;
      resp_pa    <= '0;
      resp_ctrl  <= '0;
      resp_ref   <= 1'b0;
    end else if (accept) begin
      resp_valid <= 1'b1;
      resp_hit   <= hit;
      resp_pa    <= hit ? {hit_ent.ppn, lk_va[TLB_OFF_W-1:0]} : '0;
      resp_ctrl  <= hit ? hit_ent.ctrl : '0;
      resp_ref   <= hit && hit_ent.refd;
    end else if (resp_ready) begin
      resp_valid <= 1'b0;
    end
  end

  p_flush_empty_r9: assert property (@(posedge clk) disable iff (!rst_n)
    flush |=> valid_vec == '0);
  p_clear_refs_r8: assert property (@(posedge clk) disable iff (!rst_n)
    ref_clear |=> ref_vec == '0);
  p_mark_ref_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (accept && hit && !ref_clear && !(wr_en && wr_slot == hit_idx))
    |=> ref_vec[$past(hit_idx)]);
  p_miss_zero_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (resp_valid && !resp_hit) |-> (resp_pa == '0 && resp_ctrl == '0 && !resp_ref));
  p_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (resp_valid && !resp_ready) |=> (resp_valid && $stable(resp_pa)
                                     && $stable(resp_hit) && $stable(resp_ctrl)));
  p_latency_r10: assert property (@(posedge clk) disable iff (!rst_n)
    accept |=> resp_valid);
endmodule

// File: tb/tb_tlb_asid.sv
module tb_tlb_asid;
  localparam int E = 32;

  logic clk = 0, rst_n = 0;
  logic req_valid = 0, resp_ready = 1;
  logic req_ready, resp_valid, resp_hit, resp_ref;
  logic [31:0] lk_va = 0, resp_pa;
  logic [7:0]  lk_asid = 0, wr_asid = 0;
  logic [3:0]  resp_ctrl, wr_ctrl = 0;
  logic        wr_en = 0, wr_random = 0, idx_load = 0, flush = 0, ref_clear = 0;
  logic [19:0] wr_vpn = 0, wr_ppn = 0;
  logic [5:0]  idx_value = 0;
  logic [4:0]  rnd_idx;

  tlb_asid dut (.*);

  always #5 clk = ~clk;

  int checks = 0, fails = 0;
  // bench model
  bit        m_v [E];
  bit        m_r [E];
  bit [19:0] m_vpn [E];
  bit [7:0]  m_asid [E];
  bit [19:0] m_ppn [E];
  bit [3:0]  m_ctrl [E];
  int        m_idx = 0;
  int        exp_rnd;
  bit [37:0] exp_q [$];
  string     tag_q [$];

  always @(posedge clk)
    if (!rst_n) exp_rnd <= E - 1;
    else exp_rnd <= (exp_rnd == 0) ? E - 1 : exp_rnd - 1;

  task automatic chk(input bit ok, input string tag, input longint act, input longint exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  // monitor: pops scoreboard when a response transfers
  always @(negedge clk) begin
    #1;
    if (rst_n && resp_valid && resp_ready) begin
      if (exp_q.size() == 0) chk(0, "R10 unexpected response", 1, 0);
      else begin
        bit [37:0] e;
        string t;
        e = exp_q.pop_front();
        t = tag_q.pop_front();
        chk({resp_hit, resp_pa, resp_ctrl, resp_ref} == e, t,
            {resp_hit, resp_pa, resp_ctrl, resp_ref}, e);
      end
    end
  end

  task automatic lookup(input bit [19:0] vpn, input bit [11:0] off, input bit [7:0] asid,
                        input string tag, input bit clr = 0);
    int k = -1;
    for (int i = E - 1; i >= 0; i--)
      if (m_v[i] && m_vpn[i] == vpn && m_asid[i] == asid) k = i;
    if (k >= 0) exp_q.push_back({1'b1, m_ppn[k], off, m_ctrl[k], m_r[k]});
    else exp_q.push_back('0);
    tag_q.push_back(tag);
    req_valid = 1; lk_va = {vpn, off}; lk_asid = asid; ref_clear = clr;
    @(posedge clk);
    if (clr) for (int i = 0; i < E; i++) m_r[i] = 0;
    else if (k >= 0) m_r[k] = 1;
    @(negedge clk);
    req_valid = 0; ref_clear = 0;
  endtask

  task automatic write(input bit rnd, input bit [7:0] asid, input bit [19:0] vpn,
                       input bit [19:0] ppn, input bit [3:0] ctrl, input bit fl = 0);
    int slot;
    slot = rnd ? exp_rnd : m_idx;
    if (rnd) chk(rnd_idx == exp_rnd[4:0], "R6 random slot", rnd_idx, exp_rnd);
    wr_en = 1; wr_random = rnd; wr_asid = asid; wr_vpn = vpn; wr_ppn = ppn;
    wr_ctrl = ctrl; flush = fl;
    @(posedge clk);
    m_v[slot] = !fl; m_r[slot] = 0; m_vpn[slot] = vpn; m_asid[slot] = asid;
    m_ppn[slot] = ppn; m_ctrl[slot] = ctrl;
    if (fl) for (int i = 0; i < E; i++) m_v[i] = 0;
    @(negedge clk);
    wr_en = 0; flush = 0;
  endtask

  task automatic load_idx(input int v);
    idx_load = 1; idx_value = 6'(v);
    @(posedge clk);
    if (v < E) m_idx = v;
    @(negedge clk);
    idx_load = 0;
  endtask

  initial begin
    #200000;
    chk(0, "watchdog expired", 0, 1);
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    chk(resp_valid == 0, "R11 resp_valid after reset", resp_valid, 0);
    chk(rnd_idx == 5'(E - 1), "R6 random reset value", rnd_idx, E - 1);
    rst_n = 1;
    lookup(20'h12345, 12'h678, 8'h07, "R11 empty table miss");
    lookup(20'h00000, 12'h000, 8'h00, "R3 zero vpn miss");

    // indexed write, translation and reference flag
    load_idx(5);
    write(0, 8'h07, 20'h12345, 20'hABCDE, 4'h3);
    lookup(20'h12345, 12'h678, 8'h07, "R1 hit physical address");
    lookup(20'h12345, 12'hFFF, 8'h07, "R7 reference reported after access");
    lookup(20'h12345, 12'h678, 8'h08, "R2 other asid misses");
    lookup(20'h12344, 12'h678, 8'h07, "R2 other vpn misses");

    // out-of-range index load ignored: next write still lands in slot 5
    load_idx(40);
    write(0, 8'h07, 20'h00222, 20'h11111, 4'h5);
    lookup(20'h12345, 12'h001, 8'h07, "R5 slot 5 overwritten");
    lookup(20'h00222, 12'h010, 8'h07, "R7 new write has clear reference");

    // duplicate at lower slot wins
    load_idx(2);
    write(0, 8'h07, 20'h00222, 20'h22222, 4'h6);
    lookup(20'h00222, 12'h020, 8'h07, "R4 lowest slot wins");

    // random writes
    repeat (3) @(negedge clk);
    write(1, 8'h03, 20'h0F0F0, 20'h33333, 4'h9);
    lookup(20'h0F0F0, 12'h0AB, 8'h03, "R6 random write hits");
    load_idx(exp_rnd == 0 ? E - 1 : exp_rnd);
    write(1, 8'h04, 20'h0A0A0, 20'h44444, 4'hA);
    lookup(20'h0A0A0, 12'h0CD, 8'h04, "R6 second random write");
    lookup(20'h0F0F0, 12'h0AB, 8'h03, "R6 earlier random entry kept");

    // random register wraps
    for (int c = 0; c < E + 4; c++) begin
      @(negedge clk);
      chk(rnd_idx == exp_rnd[4:0], "R6 countdown and wrap", rnd_idx, exp_rnd);
    end

    // reference clear
    lookup(20'h00222, 12'h030, 8'h07, "R7 mark slot 2");
    lookup(20'h00222, 12'h030, 8'h07, "R7 slot 2 marked");
    lookup(20'h00222, 12'h030, 8'h07, "R8 clear beats hit mark", 1);
    lookup(20'h00222, 12'h030, 8'h07, "R8 reference cleared");

    // same-cycle write and lookup: lookup sees old table
    lookup(20'h55555, 12'h0, 8'h01, "R12 pre-write miss");
    begin
      exp_q.push_back('0);
      tag_q.push_back("R12 lookup during write sees old table");
      req_valid = 1; lk_va = {20'h55555, 12'h444}; lk_asid = 8'h01;
      write(0, 8'h01, 20'h55555, 20'h66666, 4'h1);
      req_valid = 0;
    end
    lookup(20'h55555, 12'h444, 8'h01, "R12 written entry visible next");

    // back-pressure
    @(negedge clk);
    resp_ready = 0;
    lookup(20'h55555, 12'h777, 8'h01, "R10 held response");
    begin
      logic [31:0] pa0;
      pa0 = resp_pa;
      chk(req_ready == 0, "R10 req_ready low while stalled", req_ready, 0);
      repeat (3) @(negedge clk);
      chk(resp_valid && resp_pa == pa0, "R10 response stable", resp_pa, pa0);
    end
    resp_ready = 1;
    @(negedge clk);

    // flush beats same-cycle write
    write(0, 8'h09, 20'h77777, 20'h88888, 4'h2, 1);
    lookup(20'h77777, 12'h0, 8'h09, "R9 flushed write");
    lookup(20'h00222, 12'h0, 8'h07, "R9 old entry flushed");
    lookup(20'h0F0F0, 12'h0, 8'h03, "R9 random entry flushed");
    repeat (3) @(negedge clk);
    chk(exp_q.size() == 0, "R10 all responses delivered", exp_q.size(), 0);
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule